// File: doc/BRIEF.md
# Program-Pulse and Verify Sequencer

This controller writes a byte-wide image into a one-time or erasable programmable memory. It works through the addresses in ascending order. At each address it fetches the intended byte from a source read port. It then applies a program strobe of fixed length, reads the same address back with the output enable low and compares the result. Pulses are repeated until the byte matches or a pulse limit runs out. Bytes that are all ones already match an erased cell, so they can be passed over without any pulse.

Once the last address has been programmed, a second pass reads back every location and compares it with the source. This pass runs under nominal supply settings. The raised-supply and program-voltage flags are only status outputs for the external voltage control. A single-cycle start request begins a run. Busy stays high for the whole run. A successful run ends with a one-cycle done pulse. A failed run ends with an error level and the failing address.

Top module: `prog_seq`

## Requirements
- R1: After reset, busy, done and error are low, fail_addr is 0, the program strobe and output enable (both active low) are high, and all three supply flags are low.
- R2: A start pulse seen while idle makes busy high from the next cycle. Busy falls in the cycle in which done pulses or error rises, and starting a run clears any earlier error.
- R3: Each program strobe is low for exactly PULSE_CYC consecutive cycles. During that time the output enable is high and both the program-voltage flag and the raised-supply flag are high.
- R4: The cycle after every strobe, the same address is read back with the output enable low. Another pulse follows only on a mismatch, so an address needing k pulses gets exactly k.
- R5: Programming pulses reach addresses in non-decreasing order. The final pass reads addresses 0, 1, … DEPTH-1 in turn.
- R6: If an address still mismatches after MAX_PULSES pulses, error rises, fail_addr holds that address, and no further pulse is applied.
- R7: With SKIP_ERASED set, an address whose source byte is all ones receives no pulse.
- R8: The final pass runs with the nominal-supply flag high and the program-voltage flag low. Any mismatch raises error with fail_addr set to that address, and no done follows.
- R9: On success, done is high for exactly one cycle, with error low.
- R10: The strobe and output enable are never low together, and the raised-supply and nominal-supply flags are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start request, sampled while idle |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle success pulse |
| error | output | 1 | Run failed; held until the next start |
| fail_addr | output | ADDR_W | Address that failed |
| src_addr | output | ADDR_W | Source image read address |
| src_data | input | DATA_W | Source byte at src_addr, same cycle |
| dev_addr | output | ADDR_W | Memory address |
| dev_wdata | output | DATA_W | Byte to program |
| dev_pgm_n | output | 1 | Program strobe, active low |
| dev_oe_n | output | 1 | Output enable for reads, active low |
| dev_rdata | input | DATA_W | Read data, valid while dev_oe_n is low |
| vpp_on | output | 1 | Program-voltage request flag |
| hi_vcc | output | 1 | Raised-supply flag for the per-address loop |
| nom_vcc | output | 1 | Nominal-supply flag for the final pass |

## Verification
Most faults in the sequencer state would be visible on the memory pins within one pulse period. A miscounted retry counter changes the number of strobes that land on a hard address. A slipped pulse timer changes the width of the low strobe on its very next pulse. An address counter that skips or repeats a location breaks the ascending order of pulses or of final-pass reads, and this shows up at the first affected address. A wrong compare, or a wrong exit from the final pass, shows only at the end of the run, as a missing or misplaced done, or as a wrong error and fail_addr.

// File: rtl/prog_seq_pkg.sv
package prog_seq_pkg;
   typedef enum logic [2:0] {
      S_IDLE,
      S_FETCH,
      S_PULSE,
      S_PVRD,
      S_PVCMP,
      S_FVRD,
      S_FVCMP,
      S_DONE
   } pseq_state_e;

   function automatic int unsigned cnt_width(input int unsigned max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction
endpackage

// File: rtl/prog_pulse_timer.sv
module prog_pulse_timer #(
   parameter int unsigned CYC = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic last
);
   localparam int unsigned CW = prog_seq_pkg::cnt_width(CYC);
   logic [CW-1:0] cnt;

   assign last = run && (cnt == CW'(CYC - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (!run) cnt <= '0;
      else if (last) cnt <= '0;
      else           cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/prog_try_counter.sv
module prog_try_counter #(
   parameter int unsigned MAX = 25
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic inc,
   output logic at_max
);
   localparam int unsigned CW = prog_seq_pkg::cnt_width(MAX);
   logic [CW-1:0] cnt;

   assign at_max = (cnt == CW'(MAX));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (clr) cnt <= '0;
      else if (inc) cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/prog_addr_ctr.sv
module prog_addr_ctr #(
   parameter int unsigned ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              inc,
   output logic [ADDR_W-1:0] addr,
   output logic              is_last
);
   assign is_last = &addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   addr <= '0;
      else if (clr) addr <= '0;
      else if (inc) addr <= addr + 1'b1;
   end
endmodule

// File: rtl/prog_seq.sv
module prog_seq #(
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned PULSE_CYC   = 10,
   parameter int unsigned MAX_PULSES  = 25,
   parameter bit          SKIP_ERASED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              busy,
   output logic              done,
   output logic              error,
   output logic [ADDR_W-1:0] fail_addr,
   output logic [ADDR_W-1:0] src_addr,
   input  logic [DATA_W-1:0] src_data,
   output logic [ADDR_W-1:0] dev_addr,
   output logic [DATA_W-1:0] dev_wdata,
   output logic              dev_pgm_n,
   output logic              dev_oe_n,
   input  logic [DATA_W-1:0] dev_rdata,
   output logic              vpp_on,
   output logic              hi_vcc,
   output logic              nom_vcc
);
   import prog_seq_pkg::*;

   if (ADDR_W < 1)     begin : g_bad_aw  $error("ADDR_W must be at least 1");     end
   if (DATA_W < 1)     begin : g_bad_dw  $error("DATA_W must be at least 1");     end
   if (PULSE_CYC < 1)  begin : g_bad_pc  $error("PULSE_CYC must be at least 1");  end
   if (MAX_PULSES < 1) begin : g_bad_mp  $error("MAX_PULSES must be at least 1"); end

   pseq_state_e       st, nxt;
   logic [DATA_W-1:0] data_q;
   logic [ADDR_W-1:0] addr;
   logic              addr_last, a_clr, a_inc;
   logic              t_clr, t_inc, at_max;
   logic              pulse_last, set_err, skip_byte;
   logic              err_q;
   logic [ADDR_W-1:0] fail_q;

   prog_addr_ctr #(.ADDR_W(ADDR_W)) u_addr (
      .clk(clk), .rst_n(rst_n), .clr(a_clr), .inc(a_inc),
      .addr(addr), .is_last(addr_last));

   prog_pulse_timer #(.CYC(PULSE_CYC)) u_timer (
      .clk(clk), .rst_n(rst_n), .run(st == S_PULSE), .last(pulse_last));

   prog_try_counter #(.MAX(MAX_PULSES)) u_tries (
      .clk(clk), .rst_n(rst_n), .clr(t_clr), .inc(t_inc), .at_max(at_max));

   if (SKIP_ERASED) begin : g_skip
      assign skip_byte = &src_data;
   end else begin : g_noskip
      assign skip_byte = 1'b0;
   end

   always_comb begin
      nxt     = st;
      a_clr   = 1'b0;
      a_inc   = 1'b0;
      t_clr   = 1'b0;
      t_inc   = 1'b0;
      set_err = 1'b0;
      case (st)
         S_IDLE: if (start) begin
            a_clr = 1'b1;
            nxt   = S_FETCH;
         end
         S_FETCH: begin
            if (skip_byte) begin
               if (addr_last) begin
                  a_clr = 1'b1;
                  nxt   = S_FVRD;
               end else begin
                  a_inc = 1'b1;
               end
            end else begin
               t_clr = 1'b1;
               nxt   = S_PULSE;
            end
         end
         S_PULSE: if (pulse_last) begin
            t_inc = 1'b1;
            nxt   = S_PVRD;
         end
         S_PVRD: nxt = S_PVCMP;
         S_PVCMP: begin
            if (dev_rdata == data_q) begin
               if (addr_last) begin
                  a_clr = 1'b1;
                  nxt   = S_FVRD;
               end else begin
                  a_inc = 1'b1;
                  nxt   = S_FETCH;
               end
            end else if (at_max) begin
               set_err = 1'b1;
               nxt     = S_IDLE;
            end else begin
               nxt = S_PULSE;
            end
         end
         S_FVRD: nxt = S_FVCMP;
         S_FVCMP: begin
            if (dev_rdata != src_data) begin
               set_err = 1'b1;
               nxt     = S_IDLE;
            end else if (addr_last) begin
               nxt = S_DONE;
            end else begin
               a_inc = 1'b1;
               nxt   = S_FVRD;
            end
         end
         S_DONE:  nxt = S_IDLE;
         default: nxt = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= S_IDLE;
         data_q <= '0;
         err_q  <= 1'b0;
         fail_q <= '0;
      end else begin
         st <= nxt;
         if (st == S_FETCH) data_q <= src_data;
         if (st == S_IDLE && start) begin
            err_q <= 1'b0;
         end else if (set_err) begin
            err_q  <= 1'b1;
            fail_q <= addr;
         end
      end
   end

   assign src_addr  = addr;
   assign dev_addr  = addr;
   assign dev_wdata = data_q;
   assign dev_pgm_n = (st != S_PULSE);
   assign dev_oe_n  = !(st == S_PVRD || st == S_PVCMP || st == S_FVRD || st == S_FVCMP);
   assign vpp_on    = (st == S_FETCH || st == S_PULSE || st == S_PVRD || st == S_PVCMP);
   assign hi_vcc    = vpp_on;
   assign nom_vcc   = (st == S_FVRD || st == S_FVCMP);
   assign busy      = !(st == S_IDLE || st == S_DONE);
   assign done      = (st == S_DONE);
   assign error     = err_q;
   assign fail_addr = fail_q;
endmodule

// File: rtl/prog_seq_checker.sv
module prog_seq_checker #(
   parameter int unsigned PULSE_CYC = 10
) (
   input logic clk,
   input logic rst_n,
   input logic start,
   input logic busy,
   input logic done,
   input logic error,
   input logic dev_pgm_n,
   input logic dev_oe_n,
   input logic vpp_on,
   input logic hi_vcc,
   input logic nom_vcc
);
   int unsigned lowc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         lowc <= 0;
      else if (!dev_pgm_n) lowc <= lowc + 1;
      else                lowc <= 0;
   end

   a_r10_strobe_vs_read: assert property (@(posedge clk) disable iff (!rst_n)
      !(!dev_pgm_n && !dev_oe_n));
   a_r10_supply_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(hi_vcc && nom_vcc));
   a_r3_pulse_flags: assert property (@(posedge clk) disable iff (!rst_n)
      !dev_pgm_n |-> (vpp_on && hi_vcc && dev_oe_n));
   a_r3_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dev_pgm_n) |-> (lowc == PULSE_CYC));
   a_r4_read_after_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dev_pgm_n) |-> !dev_oe_n);
   a_r8_final_flags: assert property (@(posedge clk) disable iff (!rst_n)
      nom_vcc |-> (!vpp_on && dev_pgm_n));
   a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r9_done_clean: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && !error));
   a_r2_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));
   a_r6_error_stops: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(error) |-> (!busy && dev_pgm_n));
endmodule

bind prog_seq prog_seq_checker #(.PULSE_CYC(PULSE_CYC)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
   .error(error), .dev_pgm_n(dev_pgm_n), .dev_oe_n(dev_oe_n),
   .vpp_on(vpp_on), .hi_vcc(hi_vcc), .nom_vcc(nom_vcc));

// File: tb/prog_seq_test.sv
module prog_seq_test;
   localparam int CLK_PERIOD = 10;
   localparam int AW    = 4;
   localparam int DW    = 8;
   localparam int DEPTH = 1 << AW;
   localparam int PC    = 10;
   localparam int MAXP  = 25;
   localparam int SKIPA = 3;
   localparam int NVEC  = 7;
   // fields: hard[20:15] stuck_en[14] stuck_a[13:10] flip_en[9] flip_a[8:5] exp_err[4] exp_a[3:0]
   localparam logic [20:0] VEC [NVEC] = '{
      {6'd1,  1'b0, 4'd0, 1'b0, 4'd0, 1'b0, 4'd0},
      {6'd3,  1'b0, 4'd0, 1'b0, 4'd0, 1'b0, 4'd0},
      {6'd25, 1'b0, 4'd0, 1'b0, 4'd0, 1'b0, 4'd0},
      {6'd2,  1'b1, 4'd6, 1'b0, 4'd0, 1'b1, 4'd6},
      {6'd1,  1'b0, 4'd0, 1'b1, 4'd9, 1'b1, 4'd9},
      {6'd1,  1'b1, 4'd0, 1'b0, 4'd0, 1'b1, 4'd0},
      {6'd4,  1'b1, 4'd3, 1'b0, 4'd0, 1'b0, 4'd0}
   };

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
   logic busy, done, error, dev_pgm_n, dev_oe_n, vpp_on, hi_vcc, nom_vcc;
   logic [AW-1:0] fail_addr, src_addr, dev_addr;
   logic [DW-1:0] src_data, dev_wdata, dev_rdata;

   int checks = 0, errors = 0;
   int cur_s = 0, cur_hard = 1, cur_stuck_a = 0, cur_flip_a = 0;
   bit cur_stuck = 0, cur_flip = 0, erase = 1;

   logic [DW-1:0] mem [DEPTH];
   int pcnt [DEPTH];
   int pulses, lowc, last_pa, fvp, fvn, donec;
   int v_width, v_verify, v_order, v_skip, v_excl;
   bit pend, flipped, fvs;
   logic [AW-1:0] p_addr;
   logic [DW-1:0] p_data;

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [DW-1:0] img(input int s, input int a);
      if (a == SKIPA) return 8'hFF;
      return DW'(((a * 37 + s * 11) ^ 8'h5A) & 8'hFE);
   endfunction

   function automatic int need(input int a);
      if (cur_stuck && a == cur_stuck_a) return MAXP + 1;
      return cur_hard;
   endfunction

   assign src_data  = img(cur_s, int'(src_addr));
   assign dev_rdata = dev_oe_n ? '1 : mem[dev_addr];

   prog_seq #(.ADDR_W(AW), .DATA_W(DW), .PULSE_CYC(PC), .MAX_PULSES(MAXP),
              .SKIP_ERASED(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
      .error(error), .fail_addr(fail_addr), .src_addr(src_addr),
      .src_data(src_data), .dev_addr(dev_addr), .dev_wdata(dev_wdata),
      .dev_pgm_n(dev_pgm_n), .dev_oe_n(dev_oe_n), .dev_rdata(dev_rdata),
      .vpp_on(vpp_on), .hi_vcc(hi_vcc), .nom_vcc(nom_vcc));

   // memory model plus port monitors
   always_ff @(posedge clk) begin
      if (erase) begin
         for (int i = 0; i < DEPTH; i++) begin
            mem[i]  <= '1;
            pcnt[i] <= 0;
         end
         pulses <= 0; lowc <= 0; last_pa <= 0; fvp <= 0; fvn <= 0; donec <= 0;
         v_width <= 0; v_verify <= 0; v_order <= 0; v_skip <= 0; v_excl <= 0;
         pend <= 0; flipped <= 0; fvs <= 0; p_addr <= '0; p_data <= '0;
      end else begin
         if (!dev_pgm_n) begin
            pend   <= 1;
            p_addr <= dev_addr;
            p_data <= dev_wdata;
            lowc   <= lowc + 1;
            if (int'(dev_addr) == SKIPA) v_skip <= v_skip + 1;
         end else begin
            if (lowc != 0 && lowc != PC) v_width <= v_width + 1;
            lowc <= 0;
            if (pend) begin
               pend <= 0;
               if (dev_oe_n) v_verify <= v_verify + 1;
               if (int'(p_addr) < last_pa) v_order <= v_order + 1;
               last_pa <= int'(p_addr);
               pcnt[p_addr] <= pcnt[p_addr] + 1;
               pulses <= pulses + 1;
               if (pcnt[p_addr] + 1 >= need(int'(p_addr)))
                  mem[p_addr] <= mem[p_addr] & p_data;
            end
         end
         if (cur_flip && nom_vcc && !flipped) begin
            mem[cur_flip_a] <= mem[cur_flip_a] ^ 8'h01;
            flipped <= 1;
         end
         if (nom_vcc && !dev_oe_n) begin
            if (!fvs) begin
               if (dev_addr != 0) v_order <= v_order + 1;
               fvs <= 1; fvp <= int'(dev_addr); fvn <= 1;
            end else if (int'(dev_addr) != fvp) begin
               if (int'(dev_addr) != fvp + 1) v_order <= v_order + 1;
               fvp <= int'(dev_addr); fvn <= fvn + 1;
            end
         end
         if ((!dev_pgm_n && !dev_oe_n) || (hi_vcc && nom_vcc)) v_excl <= v_excl + 1;
         if (done) donec <= donec + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic run_vec(input int s);
      logic [20:0] v;
      int exp_p, t, na;
      bit eerr, stuck_eff, fin;
      v = VEC[s];
      cur_s = s; cur_hard = int'(v[20:15]); cur_stuck = v[14];
      cur_stuck_a = int'(v[13:10]); cur_flip = v[9]; cur_flip_a = int'(v[8:5]);
      eerr = v[4];
      stuck_eff = cur_stuck && cur_stuck_a != SKIPA;
      na = 0;
      for (int a = 0; a < DEPTH; a++) begin
         if (a != SKIPA && (!stuck_eff || a < cur_stuck_a)) na++;
      end
      exp_p = na * cur_hard + (stuck_eff ? MAXP : 0);
      @(negedge clk); erase = 1;
      @(negedge clk); erase = 0;
      start = 1;
      @(negedge clk); start = 0;
      chk(busy == 1'b1 && error == 1'b0, "R2 busy after start, error cleared", busy, 1);
      t = 0; fin = 0;
      while (!fin && t < 20000) begin
         @(negedge clk); t++;
         if (done || error) fin = 1;
      end
      chk(fin, "R2 run ends", int'(fin), 1);
      chk(busy == 1'b0, "R2 busy low at end", busy, 0);
      repeat (3) @(negedge clk);
      chk(error == eerr, "R6/R8 error outcome", error, eerr);
      if (eerr) chk(fail_addr == v[3:0], "R6/R8 fail address", fail_addr, v[3:0]);
      chk(donec == (eerr ? 0 : 1), "R9 done pulse count", donec, eerr ? 0 : 1);
      chk(pulses == exp_p, "R4 total pulses (R6 limit)", pulses, exp_p);
      chk(v_width == 0, "R3 pulse width", v_width, 0);
      chk(v_verify == 0, "R4 read after pulse", v_verify, 0);
      chk(v_order == 0, "R5 address order", v_order, 0);
      chk(v_skip == 0, "R7 no pulse on erased byte", v_skip, 0);
      chk(v_excl == 0, "R10 exclusive controls", v_excl, 0);
      if (!eerr) begin
         chk(fvn == DEPTH, "R8 final pass covers all", fvn, DEPTH);
         for (int a = 0; a < DEPTH; a++)
            chk(mem[a] == img(s, a), "R8 image programmed", mem[a], img(s, a));
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(busy == 0 && done == 0 && error == 0, "R1 status idle", {busy, done, error}, 0);
      chk(dev_pgm_n && dev_oe_n, "R1 strobes high", {dev_pgm_n, dev_oe_n}, 3);
      chk(!vpp_on && !hi_vcc && !nom_vcc, "R1 flags low", {vpp_on, hi_vcc, nom_vcc}, 0);
      chk(fail_addr == 0, "R1 fail_addr", fail_addr, 0);
      rst_n = 1;
      @(negedge clk);
      for (int s = 0; s < NVEC; s++) run_vec(s);
      // directed: reset in the middle of a pulse returns to idle
      cur_s = 1; cur_hard = 3; cur_stuck = 0; cur_flip = 0;
      @(negedge clk); erase = 1;
      @(negedge clk); erase = 0; start = 1;
      @(negedge clk); start = 0;
      repeat (5) @(negedge clk);
      chk(dev_pgm_n == 0, "R3 pulse under way", dev_pgm_n, 0);
      rst_n = 0;
      @(negedge clk);
      chk(busy == 0 && dev_pgm_n && dev_oe_n && !vpp_on, "R1 reset mid-run",
          {busy, dev_pgm_n, dev_oe_n, vpp_on}, 6);
      rst_n = 1;
      repeat (4) @(negedge clk);
      chk(busy == 0 && done == 0, "R2 no start stays idle", {busy, done}, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog R2 actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule